// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit executes single-operand bit manipulations for an integer datapath. It picks one bit of an operand by index, copies that bit into the carry flag, and may then clear or invert the bit and send the modified operand back for write-back. The same unit also runs an AND-based comparison that only updates flags, and a byte-set operation that writes 1 or 0 into the low byte of a destination depending on the current carry flag.

The carry and zero flags are held inside the unit, so a sequence of operations sees the flags left by the one before it. Each accepted request produces a result one clock later. An illegal operand size or an unknown operation raises an error pulse instead of a write, and the flags stay as they were.

Top module: `bit_test_unit`

## Requirements
- R1: After a synchronous reset, carry_flag, zero_flag, out_valid, wr_en and out_err are all 0.
- R2: Operation code 0 (bit test) sets carry_flag to bit N of opnd_a, asserts no write, and leaves zero_flag unchanged.
- R3: Operation code 1 (test and reset) sets carry_flag to the old bit N, writes opnd_a with bit N cleared, and leaves zero_flag unchanged; 0x5A with index 1 gives 0x58 with carry 1, and a repeat gives 0x58 with carry 0.
- R4: Operation code 2 (test and complement) sets carry_flag to the old bit N, writes opnd_a with bit N inverted, and leaves zero_flag unchanged; 0x5A with index 0 gives 0x5B with carry 0, and a repeat gives 0x5A with carry 1.
- R5: The bit index is taken modulo the operand width (16, 32 or 64); written data keeps every bit other than the selected one, including bits above the operand width.
- R6: Operand size codes are 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits; operation codes 0 to 2 with size code 0 raise out_err, assert no write, and change no flag.
- R7: Operation code 3 (AND test) forms opnd_a AND opnd_b restricted to the operand width, sets zero_flag to 1 exactly when that is zero, clears carry_flag, and asserts no write; every size is legal.
- R8: Operation code 4 (set on carry) with size code 0 writes opnd_a with its low byte replaced by 1 when carry_flag is set and by 0 otherwise, and changes no flag; any other size raises out_err with no write.
- R9: Operation codes 5, 6 and 7 raise out_err, assert no write and change no flag.
- R10: A request accepted with in_valid is answered one cycle later by out_valid; wr_en and out_err are only ever asserted together with out_valid, never both at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op_code | input | 3 | Operation select (see R2 to R9) |
| size_code | input | 2 | Operand size select (see R6) |
| opnd_a | input | 64 | Operand tested and modified |
| opnd_b | input | 64 | Second operand for the AND test |
| bit_idx | input | 6 | Index of the bit to test |
| out_valid | output | 1 | Result of the previous cycle's request |
| wr_en | output | 1 | Write-back of wr_data requested |
| wr_data | output | 64 | Value to write back |
| out_err | output | 1 | Request was rejected |
| carry_flag | output | 1 | Current carry flag |
| zero_flag | output | 1 | Current zero flag |

## Verification
A wrong internal state here shows up directly at the ports one cycle after the request: a bad bit-select mask appears as a wrong carry_flag or a wrong wr_data bit, and a bad legality decode as a missing or spurious out_err or wr_en. Flag corruption is more latent, since a wrongly updated zero_flag or carry_flag is seen at once on the flag outputs but also propagates into the next set-on-carry result. The sweep covers every size, operation code and bit index so that index wrapping and size rejection are each seen at the cycle they occur.

// File: rtl/btu_pkg.sv
package btu_pkg;

    parameter int XLEN  = 64;
    parameter int IDX_W = $clog2(XLEN);

    typedef enum logic [2:0] {
        OP_BT   = 3'd0,
        OP_BTR  = 3'd1,
        OP_BTC  = 3'd2,
        OP_TEST = 3'd3,
        OP_SETC = 3'd4
    } btu_op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } btu_size_e;

    typedef struct packed {
        logic            err;
        logic            wr;
        logic [XLEN-1:0] data;
        logic            upd_c;
        logic            carry;
        logic            upd_z;
        logic            zero;
    } btu_result_t;

    // Mask applied to the bit index so that it wraps at the operand width.
    function automatic logic [IDX_W-1:0] idx_wrap(input logic [1:0] sz);
        logic [IDX_W-1:0] m;
        case (sz)
            SZ_8:    m = IDX_W'(7);
            SZ_16:   m = IDX_W'(15);
            SZ_32:   m = IDX_W'(31);
            default: m = IDX_W'(XLEN - 1);
        endcase
        return m;
    endfunction

    // Mask of the bits that belong to an operand of the given size.
    function automatic logic [XLEN-1:0] width_mask(input logic [1:0] sz);
        logic [XLEN-1:0] m;
        case (sz)
            SZ_8:    m = XLEN'(64'h0000_0000_0000_00FF);
            SZ_16:   m = XLEN'(64'h0000_0000_0000_FFFF);
            SZ_32:   m = XLEN'(64'h0000_0000_FFFF_FFFF);
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/btu_bit_mask.sv
module btu_bit_mask
    import btu_pkg::*;
(
    input  logic [1:0]       size_code,
    input  logic [IDX_W-1:0] bit_idx,
    output logic [XLEN-1:0]  onehot
);
    logic [IDX_W-1:0] eff_idx;

    assign eff_idx = bit_idx & idx_wrap(size_code);

    for (genvar i = 0; i < XLEN; i++) begin : g_sel
        assign onehot[i] = (eff_idx == IDX_W'(i));
    end
endmodule

// File: rtl/btu_exec.sv
module btu_exec
    import btu_pkg::*;
(
    input  logic [2:0]      op_code,
    input  logic [1:0]      size_code,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic [XLEN-1:0] onehot,
    input  logic            carry_in,
    output btu_result_t     res
);
    logic            known_op;
    logic            bit_class;
    logic            illegal;
    logic            sel_bit;
    logic [XLEN-1:0] anded;

    assign known_op  = (op_code <= 3'd4);
    assign bit_class = (op_code <= 3'd2);
    assign illegal   = !known_op
                     || (bit_class && size_code == SZ_8)
                     || (op_code == OP_SETC && size_code != SZ_8);
    assign sel_bit   = |(opnd_a & onehot);
    assign anded     = opnd_a & opnd_b & width_mask(size_code);

    always_comb begin
        res       = '0;
        res.data  = opnd_a;
        if (illegal) begin
            res.err = 1'b1;
        end else begin
            case (op_code)
                OP_BT: begin
                    res.upd_c = 1'b1;
                    res.carry = sel_bit;
                end
                OP_BTR: begin
                    res.upd_c = 1'b1;
                    res.carry = sel_bit;
                    res.wr    = 1'b1;
                    res.data  = opnd_a & ~onehot;
                end
                OP_BTC: begin
                    res.upd_c = 1'b1;
                    res.carry = sel_bit;
                    res.wr    = 1'b1;
                    res.data  = opnd_a ^ onehot;
                end
                OP_TEST: begin
                    res.upd_c = 1'b1;
                    res.carry = 1'b0;
                    res.upd_z = 1'b1;
                    res.zero  = (anded == '0);
                end
                default: begin
                    res.wr   = 1'b1;
                    res.data = {opnd_a[XLEN-1:8], 7'b0, carry_in};
                end
            endcase
        end
    end
endmodule

// File: rtl/btu_flags.sv
module btu_flags (
    input  logic clk,
    input  logic rst,
    input  logic upd_c,
    input  logic carry_nxt,
    input  logic upd_z,
    input  logic zero_nxt,
    output logic carry_q,
    output logic zero_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= 1'b0;
            zero_q  <= 1'b0;
        end else begin
            if (upd_c) carry_q <= carry_nxt;
            if (upd_z) zero_q  <= zero_nxt;
        end
    end
endmodule

// File: rtl/bit_test_unit.sv
module bit_test_unit
    import btu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       op_code,
    input  logic [1:0]       size_code,
    input  logic [XLEN-1:0]  opnd_a,
    input  logic [XLEN-1:0]  opnd_b,
    input  logic [IDX_W-1:0] bit_idx,
    output logic             out_valid,
    output logic             wr_en,
    output logic [XLEN-1:0]  wr_data,
    output logic             out_err,
    output logic             carry_flag,
    output logic             zero_flag
);
    logic [XLEN-1:0] onehot;
    btu_result_t     res;

    btu_bit_mask u_mask (
        .size_code (size_code),
        .bit_idx   (bit_idx),
        .onehot    (onehot)
    );

    btu_exec u_exec (
        .op_code   (op_code),
        .size_code (size_code),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .onehot    (onehot),
        .carry_in  (carry_flag),
        .res       (res)
    );

    btu_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .upd_c     (in_valid && res.upd_c),
        .carry_nxt (res.carry),
        .upd_z     (in_valid && res.upd_z),
        .zero_nxt  (res.zero),
        .carry_q   (carry_flag),
        .zero_q    (zero_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            out_err   <= 1'b0;
            wr_data   <= '0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid && res.wr;
            out_err   <= in_valid && res.err;
            if (in_valid) wr_data <= res.data;
        end
    end
endmodule

// File: rtl/bit_test_unit_chk.sv
module bit_test_unit_chk
    import btu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [2:0]       op_code,
    input logic [1:0]       size_code,
    input logic [XLEN-1:0]  opnd_a,
    input logic [IDX_W-1:0] bit_idx,
    input logic             out_valid,
    input logic             wr_en,
    input logic             out_err,
    input logic             carry_flag,
    input logic             zero_flag
);
    logic probe_bit;
    assign probe_bit = opnd_a[bit_idx & idx_wrap(size_code)];

    p_wr_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en || out_err) |-> out_valid);

    p_err_excl_wr_r10: assert property (@(posedge clk) disable iff (rst)
        out_err |-> !wr_en);

    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_bt_carry_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 3'd0 && size_code != 2'd0)
        |=> (!wr_en && carry_flag == $past(probe_bit)));

    p_zero_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code <= 3'd2) |=> $stable(zero_flag));

    p_byte_reject_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code <= 3'd2 && size_code == 2'd0)
        |=> (out_err && $stable(carry_flag)));

    p_test_no_write_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 3'd3) |=> (!wr_en && !carry_flag));

    p_setc_size_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 3'd4 && size_code != 2'd0) |=> out_err);

    p_reserved_op_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code > 3'd4)
        |=> (out_err && $stable(carry_flag) && $stable(zero_flag)));
endmodule

bind bit_test_unit bit_test_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op_code    (op_code),
    .size_code  (size_code),
    .opnd_a     (opnd_a),
    .bit_idx    (bit_idx),
    .out_valid  (out_valid),
    .wr_en      (wr_en),
    .out_err    (out_err),
    .carry_flag (carry_flag),
    .zero_flag  (zero_flag)
);

// File: tb/bit_test_unit_test.sv
module bit_test_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [1:0]  size_code = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [5:0]  bit_idx = '0;
    logic        out_valid, wr_en, out_err, carry_flag, zero_flag;
    logic [63:0] wr_data;

    int checks = 0;
    int errors = 0;
    logic exp_c = 1'b0;
    logic exp_z = 1'b0;

    always #10 clk = ~clk;

    bit_test_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
        .size_code(size_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .bit_idx(bit_idx), .out_valid(out_valid), .wr_en(wr_en),
        .wr_data(wr_data), .out_err(out_err), .carry_flag(carry_flag),
        .zero_flag(zero_flag)
    );

    task automatic report(input string tag, input logic ok,
                          input logic [69:0] act, input logic [69:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual {v,we,err,c,z,data}=%h expected %h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; applies a request and checks it one cycle on.
    task automatic run_op(input logic [2:0] o, input logic [1:0] s,
                          input logic [63:0] a, input logic [63:0] b,
                          input logic [5:0] ix);
        int width, e;
        logic bad, ewe, nc, nz;
        logic [63:0] ed, prod;
        string tag;
        width = 8 << s;
        e     = ix % width;
        bad   = (o > 3'd4) || (o <= 3'd2 && s == 2'd0) || (o == 3'd4 && s != 2'd0);
        ewe = 1'b0; ed = a; nc = exp_c; nz = exp_z;
        if (!bad) begin
            case (o)
                3'd0: nc = a[e];
                3'd1: begin nc = a[e]; ewe = 1'b1; ed = a & ~(64'd1 << e); end
                3'd2: begin nc = a[e]; ewe = 1'b1; ed = a ^ (64'd1 << e); end
                3'd3: begin
                    prod = a & b;
                    if (width < 64) prod = prod % (64'd1 << width);
                    nc = 1'b0; nz = (prod == 64'd0);
                end
                default: begin ewe = 1'b1; ed = {a[63:8], 8'(exp_c)}; end
            endcase
        end
        if (bad) tag = (o > 3'd4) ? "R9" : (o == 3'd4) ? "R8" : "R6";
        else if (o <= 3'd2 && ix >= width) tag = "R5";
        else case (o)
            3'd0: tag = "R2";  3'd1: tag = "R3";  3'd2: tag = "R4";
            3'd3: tag = "R7";  default: tag = "R8";
        endcase
        in_valid = 1'b1; op_code = o; size_code = s;
        opnd_a = a; opnd_b = b; bit_idx = ix;
        @(negedge clk);
        exp_c = nc; exp_z = nz;
        report(tag,
               out_valid && wr_en == ewe && out_err == bad && carry_flag == nc &&
               zero_flag == nz && (!ewe || wr_data == ed),
               {out_valid, wr_en, out_err, carry_flag, zero_flag, 1'b0, wr_data},
               {1'b1, ewe, bad, nc, nz, 1'b0, ed});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        report("R1", !out_valid && !wr_en && !out_err && !carry_flag && !zero_flag,
               {out_valid, wr_en, out_err, carry_flag, zero_flag, 65'd0}, 70'd0);

        // R3 worked example, twice
        run_op(3'd1, 2'd1, 64'h5A, 64'h0, 6'd1);
        run_op(3'd1, 2'd1, 64'h58, 64'h0, 6'd1);
        // R4 worked example, twice
        run_op(3'd2, 2'd2, 64'h5A, 64'h0, 6'd0);
        run_op(3'd2, 2'd2, 64'h5B, 64'h0, 6'd0);
        // R7 worked examples
        run_op(3'd3, 2'd0, 64'hF0, 64'h18, 6'd0);
        run_op(3'd3, 2'd0, 64'hF0, 64'h00, 6'd0);
        run_op(3'd3, 2'd1, 64'hFFFF_0000, 64'hFFFF_0000, 6'd0);
        // R8: set on carry after carry set and after carry cleared
        run_op(3'd0, 2'd3, 64'h2, 64'h0, 6'd1);
        run_op(3'd4, 2'd0, 64'hABCD_00FF, 64'h0, 6'd0);
        run_op(3'd0, 2'd3, 64'h2, 64'h0, 6'd0);
        run_op(3'd4, 2'd0, 64'hFF, 64'h0, 6'd0);

        // Sweep: every size, op code and index, back to back
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 8; o++) begin
                for (int ix = 0; ix < 64; ix++) begin
                    logic [63:0] a, b;
                    a = (64'(ix * 131 + o * 17 + s * 7 + 1)) * 64'h9E37_79B9_7F4A_7C15;
                    b = {a[31:0], a[63:32]} & ((ix % 5 == 0) ? 64'h0 : 64'hFFFF_FFFF_FFFF_FFFF);
                    run_op(3'(o), 2'(s), a, b, 6'(ix));
                end
            end
        end

        // R10: no request, no response
        in_valid = 1'b0;
        @(negedge clk);
        report("R10", !out_valid && !wr_en && !out_err,
               {out_valid, wr_en, out_err, 67'd0}, 70'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule